// File: doc/BRIEF.md
# Converter Host Port: Ready Flag and Split Output Bus

This block is the side of a successive-approximation converter that a host processor sees. A conversion sequencer steps through thirteen clock periods and raises a one-cycle done strobe during the last one, together with the finished 10-bit result. The host port captures that result into an output register. The register keeps the captured value through the whole next conversion, so the host can read it at any time without tearing.

The captured word goes out on a three-state bus that has two independent active-low enables. One enable gates the upper eight bits and the other gates the lower two, so a byte-wide host can read the word in two accesses. A data-ready flag tells the host that a new word is waiting. The flag rises as the sequencer wraps from period 13 to period 1. It falls when both of these have happened: the sequencer has left period 1, and a start command has been seen. A separate active-low ready-reset input clears the flag at once, without waiting for a clock edge, and keeps it from rising while it is held low.

Top module: `adc_host_port`

## Requirements
- R1: While `rst` is high at a rising clock edge, the flag and the output register both go to zero.
- R2: The output register loads `seq_result` at the edge where `seq_done` is high. At every other edge it keeps its value, whatever `seq_result` does.
- R3: While `oe_hi_n` is low, bus bits 9 down to 2 carry register bits 9 down to 2 and their `bus_drv` bits are 1. While it is high, those lines are Z and their `bus_drv` bits are 0.
- R4: While `oe_lo_n` is low, bus bits 1 and 0 carry register bits 1 and 0 and their `bus_drv` bits are 1. While it is high, those lines are Z and their `bus_drv` bits are 0.
- R5: At the edge where `seq_done` is high and `rdy_clr_n` is high, `data_ready` goes to 1.
- R6: If `start_n` is low while the flag is high and `seq_period` is 1, the flag falls at the edge that ends period 1.
- R7: If `start_n` stays high through period 1, the flag stays high while the sequencer idles in period 2. It falls at the first edge at which `start_n` is sampled low.
- R8: A low level on `rdy_clr_n` forces `data_ready` to 0 with no clock edge needed.
- R9: If `rdy_clr_n` is low at the done edge, the flag stays 0 but the register still loads the result.
- R10: The two output enables have no effect on the flag or on the register contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| seq_period | input | 4 | Current sequencer period number, 1 to 13 |
| seq_done | input | 1 | High during the last cycle of period 13 |
| seq_result | input | 10 | Finished conversion word, valid with `seq_done` |
| start_n | input | 1 | Start command, active low |
| rdy_clr_n | input | 1 | Asynchronous clear of the ready flag, active low |
| oe_hi_n | input | 1 | Drive enable for bus bits 9 to 2, active low |
| oe_lo_n | input | 1 | Drive enable for bus bits 1 and 0, active low |
| bus_q | output | 10 | Three-state data bus |
| bus_drv | output | 10 | Per-bit drive enable of `bus_q` |
| data_ready | output | 1 | New-data flag |

## Verification
The hardest case to reach from the ports is a flag that has to wait for a late start. The sequencer has to wrap to period 1 while `start_n` is high and then sit in period 2 for several cycles, and the flag must stay up that whole time and fall only at the edge that samples the start. The stimulus plays the sequencer itself and holds period 2 across a run of idle cycles before it lowers `start_n`. The asynchronous clear is then applied in the middle of a clock period while the flag is high in that idle state, so that its effect shows before any edge arrives.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  parameter int DEF_DATA_W   = 10;
  parameter int DEF_LO_W     = 2;
  parameter int DEF_PERIOD_W = 4;
  parameter int DEF_FIRST    = 1;
endpackage

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/adc_ready_flag.sv
module adc_ready_flag #(
  parameter int PERIOD_W = 4,
  parameter int FIRST    = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_n,
  input  logic                done,
  input  logic [PERIOD_W-1:0] period,
  input  logic                start_n,
  output logic                flag
);
  localparam logic [PERIOD_W-1:0] FIRST_P = PERIOD_W'(FIRST);

  logic left_first;   // sequencer has moved past period 1
  logic start_seen;   // a start was sampled since the flag rose
  logic leave_now;
  logic seen_now;

  assign leave_now = left_first | (period == FIRST_P);
  assign seen_now  = start_seen | ~start_n;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      flag       <= 1'b0;
      left_first <= 1'b0;
      start_seen <= 1'b0;
    end else if (rst) begin
      flag       <= 1'b0;
      left_first <= 1'b0;
      start_seen <= 1'b0;
    end else if (done) begin
      flag       <= 1'b1;
      left_first <= 1'b0;
      start_seen <= 1'b0;
    end else if (flag) begin
      if (leave_now && seen_now) flag <= 1'b0;
      left_first <= leave_now;
      start_seen <= seen_now;
    end
  end
endmodule

// File: rtl/adc_bus_drive.sv
module adc_bus_drive #(
  parameter int DATA_W = 10,
  parameter int LO_W   = 2
) (
  input  logic [DATA_W-1:0] q,
  input  logic              oe_hi_n,
  input  logic              oe_lo_n,
  output logic [DATA_W-1:0] bus,
  output logic [DATA_W-1:0] drv
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i >= LO_W) begin : g_hi
      assign drv[i] = ~oe_hi_n;
    end else begin : g_lo
      assign drv[i] = ~oe_lo_n;
    end
    assign bus[i] = drv[i] ? q[i] : 1'bz;
  end
endmodule

// File: rtl/adc_host_port.sv
module adc_host_port
  import adc_host_pkg::*;
#(
  parameter int DATA_W   = DEF_DATA_W,
  parameter int LO_W     = DEF_LO_W,
  parameter int PERIOD_W = DEF_PERIOD_W,
  parameter int FIRST    = DEF_FIRST
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] seq_period,
  input  logic                seq_done,
  input  logic [DATA_W-1:0]   seq_result,
  input  logic                start_n,
  input  logic                rdy_clr_n,
  input  logic                oe_hi_n,
  input  logic                oe_lo_n,
  output logic [DATA_W-1:0]   bus_q,
  output logic [DATA_W-1:0]   bus_drv,
  output logic                data_ready
);
  logic [DATA_W-1:0] data_hold;

  adc_result_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .load(seq_done), .d(seq_result), .q(data_hold)
  );

  adc_ready_flag #(.PERIOD_W(PERIOD_W), .FIRST(FIRST)) u_flag (
    .clk(clk), .rst(rst), .clr_n(rdy_clr_n), .done(seq_done),
    .period(seq_period), .start_n(start_n), .flag(data_ready)
  );

  adc_bus_drive #(.DATA_W(DATA_W), .LO_W(LO_W)) u_bus (
    .q(data_hold), .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n),
    .bus(bus_q), .drv(bus_drv)
  );
endmodule

// File: rtl/adc_host_port_chk.sv
module adc_host_port_chk #(
  parameter int DATA_W   = 10,
  parameter int LO_W     = 2,
  parameter int PERIOD_W = 4,
  parameter int FIRST    = 1
) (
  input logic                clk,
  input logic                rst,
  input logic [PERIOD_W-1:0] seq_period,
  input logic                seq_done,
  input logic [DATA_W-1:0]   seq_result,
  input logic                start_n,
  input logic                rdy_clr_n,
  input logic                oe_hi_n,
  input logic                oe_lo_n,
  input logic [DATA_W-1:0]   bus_drv,
  input logic [DATA_W-1:0]   data_hold,
  input logic                data_ready
);
  AST_LOAD_RESULT: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> data_hold == $past(seq_result)); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !seq_done |=> $stable(data_hold)); // R2
  AST_HI_ENABLE: assert property (@(posedge clk) disable iff (rst)
    bus_drv[DATA_W-1:LO_W] == (oe_hi_n ? '0 : '1)); // R3
  AST_LO_ENABLE: assert property (@(posedge clk) disable iff (rst)
    bus_drv[LO_W-1:0] == (oe_lo_n ? '0 : '1)); // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    seq_done && rdy_clr_n |=> data_ready || !rdy_clr_n); // R5
  AST_FLAG_FREE_CLR: assert property (@(posedge clk) disable iff (rst)
    data_ready && !seq_done && !start_n && seq_period == PERIOD_W'(FIRST)
      |=> !data_ready); // R6
  AST_CLR_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
    !rdy_clr_n |-> !data_ready); // R8
endmodule

bind adc_host_port adc_host_port_chk #(
  .DATA_W(DATA_W), .LO_W(LO_W), .PERIOD_W(PERIOD_W), .FIRST(FIRST)
) u_chk (
  .clk(clk), .rst(rst), .seq_period(seq_period), .seq_done(seq_done),
  .seq_result(seq_result), .start_n(start_n), .rdy_clr_n(rdy_clr_n),
  .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n), .bus_drv(bus_drv),
  .data_hold(data_hold), .data_ready(data_ready)
);

// File: tb/adc_host_port_test.sv
module adc_host_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] seq_period = 4'd2;
  logic       seq_done = 1'b0;
  logic [9:0] seq_result = '0;
  logic       start_n = 1'b0;
  logic       rdy_clr_n = 1'b1;
  logic       oe_hi_n = 1'b1;
  logic       oe_lo_n = 1'b1;
  wire  [9:0] bus_q;
  wire  [9:0] bus_drv;
  wire        data_ready;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic       q_flag[$];
  logic [9:0] q_data[$];
  string      q_req[$];

  always #4 clk = ~clk;

  adc_host_port uut (
    .clk(clk), .rst(rst), .seq_period(seq_period), .seq_done(seq_done),
    .seq_result(seq_result), .start_n(start_n), .rdy_clr_n(rdy_clr_n),
    .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n), .bus_q(bus_q), .bus_drv(bus_drv),
    .data_ready(data_ready)
  );

  // Monitor: after each edge, compare flag and the word seen on the fully enabled bus.
  always @(posedge clk) begin
    #2;
    if (q_flag.size() > 0) begin
      logic       ef;
      logic [9:0] ed;
      string      rq;
      logic       sh, sl;
      logic [9:0] got;
      ef = q_flag.pop_front();
      ed = q_data.pop_front();
      rq = q_req.pop_front();
      sh = oe_hi_n; sl = oe_lo_n;
      force_enables();
      got = bus_q;
      oe_hi_n = sh; oe_lo_n = sl;
      total++;
      if (data_ready !== ef || got !== ed) begin
        bad++;
        $display("FAIL %s flag=%b/%b data=%h/%h", rq, data_ready, ef, got, ed);
      end
    end
  end

  task automatic force_enables();
    oe_hi_n = 1'b0; oe_lo_n = 1'b0;
    #0.1;
  endtask

  task automatic cyc(input logic done, input int per, input logic [9:0] res,
                     input logic st_n, input logic eflag, input logic [9:0] edata,
                     input string req);
    @(negedge clk);
    seq_done = done; seq_period = 4'(per); seq_result = res; start_n = st_n;
    q_flag.push_back(eflag); q_data.push_back(edata); q_req.push_back(req);
  endtask

  // Periods 2..13 with start held low; result presented on the done cycle.
  task automatic conv(input logic [9:0] res, input logic [9:0] old, input logic eset,
                      input string req);
    for (int p = 2; p <= 12; p++) cyc(1'b0, p, ~res, 1'b0, 1'b0, old, req);
    cyc(1'b1, 13, res, 1'b0, eset, res, "R5");
  endtask

  task automatic drain();
    @(posedge clk); #3;
  endtask

  task automatic chk_bus(input logic hn, input logic ln, input logic [9:0] d,
                         input string req);
    logic [9:0] eb, ed;
    oe_hi_n = hn; oe_lo_n = ln;
    #0.5;
    for (int i = 0; i < 10; i++) begin
      ed[i] = (i >= 2) ? ~hn : ~ln;
      eb[i] = ed[i] ? d[i] : 1'bz;
    end
    total++;
    if (bus_q !== eb || bus_drv !== ed) begin
      bad++;
      $display("FAIL %s bus=%b/%b drv=%b/%b", req, bus_q, eb, bus_drv, ed);
    end
    oe_hi_n = 1'b1; oe_lo_n = 1'b1;
  endtask

  initial begin
    #(8 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog flag=%b/x data=x/x", data_ready);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    // R1: reset state
    cyc(1'b0, 2, 10'h3FF, 1'b0, 1'b0, 10'h000, "R1");
    cyc(1'b0, 2, 10'h3FF, 1'b0, 1'b0, 10'h000, "R1");
    @(negedge clk); rst = 1'b0;

    // R5/R6: free-running conversion, flag up one period
    conv(10'h2A5, 10'h000, 1'b1, "R2");
    cyc(1'b0, 1, 10'h000, 1'b0, 1'b0, 10'h2A5, "R6");
    drain();
    chk_bus(1'b0, 1'b0, 10'h2A5, "R3");
    chk_bus(1'b1, 1'b0, 10'h2A5, "R3");
    chk_bus(1'b0, 1'b1, 10'h2A5, "R4");
    chk_bus(1'b1, 1'b1, 10'h2A5, "R4");

    // R2: hold through the following conversion
    conv(10'h15A, 10'h2A5, 1'b1, "R2");
    cyc(1'b0, 1, 10'h2A5, 1'b0, 1'b0, 10'h15A, "R6");

    // R7: start withheld, idle in period 2
    conv(10'h3FF, 10'h15A, 1'b1, "R2");
    cyc(1'b0, 1, 10'h000, 1'b1, 1'b1, 10'h3FF, "R7");
    for (int k = 0; k < 4; k++) cyc(1'b0, 2, 10'h000, 1'b1, 1'b1, 10'h3FF, "R7");
    cyc(1'b0, 2, 10'h000, 1'b0, 1'b0, 10'h3FF, "R7");

    // R8: asynchronous clear mid-period while idling high
    conv(10'h0F0, 10'h3FF, 1'b1, "R2");
    cyc(1'b0, 1, 10'h000, 1'b1, 1'b1, 10'h0F0, "R7");
    cyc(1'b0, 2, 10'h000, 1'b1, 1'b1, 10'h0F0, "R7");
    drain();
    rdy_clr_n = 1'b0;
    #0.5;
    total++;
    if (data_ready !== 1'b0) begin
      bad++;
      $display("FAIL R8 flag=%b/0", data_ready);
    end
    @(negedge clk); rdy_clr_n = 1'b1;
    cyc(1'b0, 2, 10'h000, 1'b1, 1'b0, 10'h0F0, "R8");
    cyc(1'b0, 2, 10'h000, 1'b0, 1'b0, 10'h0F0, "R8");

    // R9: clear held low across the done edge
    cyc(1'b0, 3, 10'h000, 1'b0, 1'b0, 10'h0F0, "R9");
    rdy_clr_n = 1'b0;
    conv(10'h155, 10'h0F0, 1'b0, "R9");
    cyc(1'b0, 1, 10'h000, 1'b1, 1'b0, 10'h155, "R9");
    @(negedge clk); rdy_clr_n = 1'b1;
    cyc(1'b0, 2, 10'h000, 1'b0, 1'b0, 10'h155, "R9");

    // R10: enables toggled during a conversion do not disturb flag or register
    for (int p = 2; p <= 12; p++) begin
      cyc(1'b0, p, 10'h0AA, 1'b0, 1'b0, 10'h155, "R10");
      oe_hi_n = p[0]; oe_lo_n = ~p[0];
    end
    cyc(1'b1, 13, 10'h301, 1'b0, 1'b1, 10'h301, "R10");
    oe_hi_n = 1'b0;
    cyc(1'b0, 1, 10'h000, 1'b0, 1'b0, 10'h301, "R10");
    oe_lo_n = 1'b0;
    drain();
    chk_bus(1'b0, 1'b0, 10'h301, "R10");

    // R1: reset mid-operation after a set
    conv(10'h111, 10'h301, 1'b1, "R2");
    @(negedge clk); rst = 1'b1; seq_done = 1'b0; seq_period = 4'd1;
    cyc(1'b0, 1, 10'h000, 1'b1, 1'b0, 10'h000, "R1");
    @(negedge clk); rst = 1'b0;
    drain();

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end
endmodule